// File: doc/BRIEF.md
# Arithmetic Sweep Pattern Source

This block feeds stimulus to logic under test. Every enabled clock it adds a fixed odd step value into an accumulator register, and it drives a slice of that register onto a 12-bit pattern bus. An odd step is coprime with the slice's modulus, so any 4096 consecutive enabled cycles present every 12-bit value exactly once. A step with many set bits makes the upper pattern bits toggle far more often than a binary counter would. A one-cycle flag marks the end of each full sweep of 4096 additions. Software may replace the step value, and the block forces the loaded value to be odd.

Several copies are meant to run side by side, each driving its own interleaved group of targets. A defect in one source then shows up as a disagreement between groups instead of staying hidden.

Top module: `acc_pattern_gen`

## Requirements
- R1: While reset is asserted and right after it, the pattern is 0 and sweep_done is 0.
- R2: On each clock edge with en high, the accumulator adds the current step modulo 2^24. The pattern is accumulator bits [11:0], so after k enabled edges with step s it reads (k*s) mod 4096.
- R3: On an edge with en low, the pattern holds its value, the sweep count does not advance, and sweep_done is 0 in the following cycle.
- R4: Over 4096 consecutive enabled cycles with the reset step, starting from reset, each of the 4096 pattern values appears exactly once.
- R5: sweep_done is high for exactly one cycle after the edge that completes every 4096th enabled addition since reset. It is low at all other times, and the accumulator keeps running.
- R6: An edge with step_ld high loads step_val with bit 0 forced to 1. The new step applies from the next edge, and an addition on the loading edge still uses the old step.
- R7: After an even step_val is loaded, 4096 consecutive enabled cycles still show all 4096 pattern values exactly once.
- R8: With the reset step, pattern bit 11 changes on more than half of the 4095 transitions in a sweep.
- R9: After reset the step is 0xCA6691, so the first enabled edge gives pattern 0x691.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Advance the accumulator on this edge |
| step_ld | input | 1 | Load a new step value on this edge |
| step_val | input | 24 | Step value to load; bit 0 is forced to 1 |
| pattern | output | 12 | Test pattern to the targets |
| sweep_done | output | 1 | One-cycle flag after each 4096th addition |

## Verification
The hardest case to reach is a pause that lands exactly at the sweep boundary. The sweep count sits at its last value, and en must be low for several cycles while sweep_done stays quiet. The stimulus gets there by running one full sweep and then 4095 more additions, holding en low there, and then making the final addition. The same sweep loops also cover a step loaded on an enabled edge and an even loaded value, and the bench checks that each sweep still covers all 4096 values.

// File: rtl/apg_pkg.sv
package apg_pkg;
  localparam int unsigned APG_ACC_W = 24;
  localparam int unsigned APG_PAT_W = 12;
  localparam logic [APG_ACC_W-1:0] APG_RESET_STEP = 24'hCA6691;

  // Force a step value odd so the pattern slice is a full-period sequence.
  function automatic logic [APG_ACC_W-1:0] make_odd(input logic [APG_ACC_W-1:0] v);
    return {v[APG_ACC_W-1:1], 1'b1};
  endfunction
endpackage

// File: rtl/apg_step_reg.sv
module apg_step_reg
  import apg_pkg::*;
#(
  parameter int unsigned ACC_W = APG_ACC_W,
  parameter logic [ACC_W-1:0] RESET_STEP = APG_RESET_STEP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [ACC_W-1:0] val,
  output logic [ACC_W-1:0] step
);
  logic [ACC_W-1:0] step_d;
  logic [ACC_W-1:0] step_q;

  always_comb begin
    step_d = step_q;
    if (ld) step_d = {val[ACC_W-1:1], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= RESET_STEP;
    else        step_q <= step_d;
  end

  assign step = step_q;
endmodule

// File: rtl/apg_accum.sv
module apg_accum #(
  parameter int unsigned ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] acc_q;

  always_comb begin
    acc_d = acc_q;
    if (en) acc_d = acc_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/apg_sweep_ctr.sv
module apg_sweep_ctr #(
  parameter int unsigned CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic done
);
  localparam logic [CNT_W-1:0] LAST = '1;

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             done_d, done_q;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (en) begin
      cnt_d  = cnt_q + 1'b1;
      done_d = (cnt_q == LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/acc_pattern_gen.sv
module acc_pattern_gen
  import apg_pkg::*;
#(
  parameter int unsigned ACC_W   = APG_ACC_W,
  parameter int unsigned PAT_W   = APG_PAT_W,
  parameter int unsigned PAT_LSB = 0,
  parameter logic [ACC_W-1:0] RESET_STEP = APG_RESET_STEP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step_ld,
  input  logic [ACC_W-1:0] step_val,
  output logic [PAT_W-1:0] pattern,
  output logic             sweep_done
);
  localparam int unsigned PAT_MSB = PAT_LSB + PAT_W - 1;

  logic [ACC_W-1:0] step_q;
  logic [ACC_W-1:0] acc_q;

  apg_step_reg #(.ACC_W(ACC_W), .RESET_STEP(RESET_STEP)) u_step (
    .clk (clk), .rst_n (rst_n), .ld (step_ld), .val (step_val), .step (step_q)
  );

  apg_accum #(.ACC_W(ACC_W)) u_acc (
    .clk (clk), .rst_n (rst_n), .en (en), .step (step_q), .acc (acc_q)
  );

  apg_sweep_ctr #(.CNT_W(PAT_W)) u_sweep (
    .clk (clk), .rst_n (rst_n), .en (en), .done (sweep_done)
  );

  generate
    if (PAT_LSB == 0) begin : g_low_slice
      assign pattern = acc_q[PAT_W-1:0];
    end else begin : g_mid_slice
      assign pattern = acc_q[PAT_MSB:PAT_LSB];
    end
  endgenerate
endmodule

// File: rtl/acc_pattern_gen_chk.sv
module acc_pattern_gen_chk #(
  parameter int unsigned ACC_W = 24,
  parameter int unsigned PAT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             step_ld,
  input logic [ACC_W-1:0] step_val,
  input logic [PAT_W-1:0] pattern,
  input logic             sweep_done,
  input logic [ACC_W-1:0] step_q,
  input logic [ACC_W-1:0] acc_q
);
  // R2: enabled edge adds the step held before that edge
  assert_acc_adds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> acc_q == $past(acc_q) + $past(step_q));

  // R3: disabled edge leaves the pattern untouched
  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pattern));

  // R3: no sweep flag without an addition on the edge before
  assert_done_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> $past(en));

  // R5: flag lasts one cycle
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> !sweep_done);

  // R6: loaded step is the value with bit 0 forced high
  assert_load_odd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_ld |=> (step_q[0] == 1'b1) && (step_q[ACC_W-1:1] == $past(step_val[ACC_W-1:1])));

  // R6: step changes only through a load
  assert_step_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !step_ld |=> $stable(step_q));
endmodule

bind acc_pattern_gen acc_pattern_gen_chk #(.ACC_W(ACC_W), .PAT_W(PAT_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .en (en), .step_ld (step_ld), .step_val (step_val),
  .pattern (pattern), .sweep_done (sweep_done), .step_q (step_q), .acc_q (acc_q)
);

// File: tb/acc_pattern_gen_test.sv
`timescale 1ns/1ps
module acc_pattern_gen_test;
  localparam int N = 4096;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        step_ld;
  logic [23:0] step_val;
  logic [11:0] pattern;
  logic        sweep_done;

  int checks = 0;
  int failures = 0;

  logic [23:0] m_acc;
  logic [23:0] m_step;
  int          m_adds;
  logic        m_done;
  int          hits [N];

  always #4 clk = ~clk;

  acc_pattern_gen uut (
    .clk (clk), .rst_n (rst_n), .en (en), .step_ld (step_ld),
    .step_val (step_val), .pattern (pattern), .sweep_done (sweep_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Apply inputs, take one edge, update the model, compare outputs.
  task automatic cyc(input logic e, input logic ld, input logic [23:0] v, input string req);
    logic [23:0] old_step;
    en = e; step_ld = ld; step_val = v;
    @(posedge clk); #1;
    old_step = m_step;
    if (ld) m_step = {v[23:1], 1'b1};
    m_done = 1'b0;
    if (e) begin
      m_acc = m_acc + old_step;
      m_adds++;
      m_done = (m_adds % N) == 0;
    end
    check(req, {20'd0, pattern}, {20'd0, m_acc[11:0]});
    check("R5", {31'd0, sweep_done}, {31'd0, m_done});
  endtask

  task automatic clear_hits();
    for (int i = 0; i < N; i++) hits[i] = 0;
  endtask

  task automatic check_hits(input string req);
    int bad = 0;
    for (int i = 0; i < N; i++) if (hits[i] != 1) bad++;
    check(req, bad, 0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int toggles;
    logic prev_msb;
    rst_n = 1'b0; en = 1'b0; step_ld = 1'b0; step_val = '0;
    m_acc = '0; m_step = 24'hCA6691; m_adds = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", {20'd0, pattern}, 32'd0);
    check("R1", {31'd0, sweep_done}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", {20'd0, pattern}, 32'd0);

    // R9: first enabled edge with the reset step
    clear_hits();
    hits[pattern]++;
    prev_msb = pattern[11];
    toggles = 0;
    cyc(1'b1, 1'b0, '0, "R9");
    check("R9", {20'd0, pattern}, 32'h691);
    // R2, R4, R8: rest of the first sweep
    for (int k = 1; k < N; k++) begin
      hits[pattern]++;
      if (pattern[11] != prev_msb) toggles++;
      prev_msb = pattern[11];
      cyc(1'b1, 1'b0, '0, "R2");
    end
    check_hits("R4");
    checks++;
    if (toggles <= 2047) begin
      failures++;
      $display("FAIL R8 actual=%0d expected>2047", toggles);
    end

    // R3: idle cycles hold the pattern
    for (int k = 0; k < 5; k++) cyc(1'b0, 1'b0, '0, "R3");

    // R5 and R3: stop one addition short of the second sweep boundary
    for (int k = 0; k < N - 1; k++) cyc(1'b1, 1'b0, '0, "R2");
    for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0, '0, "R3");
    cyc(1'b1, 1'b0, '0, "R5");
    check("R5", {31'd0, sweep_done}, 32'd1);
    cyc(1'b1, 1'b0, '0, "R5");
    check("R5", {31'd0, sweep_done}, 32'd0);

    // R6: load on an enabled edge; the old step is used for that addition
    cyc(1'b1, 1'b1, 24'h000003, "R6");
    cyc(1'b1, 1'b0, '0, "R6");

    // R7: even value loaded, then one full sweep
    cyc(1'b0, 1'b1, 24'h000100, "R6");
    clear_hits();
    for (int k = 0; k < N; k++) begin
      hits[pattern]++;
      cyc(1'b1, 1'b0, '0, "R7");
    end
    check_hits("R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule